// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and checks the parity bit of a 32-bit multiplexed address/data bus with four command/byte-enable lines. It watches the bus framing and the two ready strobes to find the clocks that carry a valid phase: the address phase, a write data phase (initiator ready low), or a read data phase (target ready low). For each such phase it registers the even parity of all 36 lines, so the parity output is valid one clock after the phase it covers. On read data phases the block is the driver and raises a parity-enable output for that clock.

When the other side drives the bus (address phases and write data phases), the incoming parity bit sampled one clock after the phase is compared with the registered result. A mismatch on an address phase pulls the system-error output low. A mismatch on a write data phase pulls the parity-error output low, except inside a special-cycle transaction. Both outputs model an open-drain pin (0 = pull low, 1 = released), each is gated by its own enable, and every detected mismatch also sets a sticky flag that stays set until a clear strobe.

Top module: `pci_par_unit`

## Requirements
- R1: `parOut` equals the even parity of the 32 address/data lines and the 4 command/byte-enable lines (XOR of all 36 bits), registered on each qualifying phase and valid in the following clock.
- R2: An address phase is the first clock with `frameN` low after a clock in which `frameN` and `irdyN` were both high; further clocks with `frameN` held low are not address phases.
- R3: `parOe` is 1 exactly in the clock after a read data phase (`isRead` = 1 and `trdyN` low inside a transaction) and 0 otherwise.
- R4: If `parIn` in the clock after an address phase differs from `parOut`, and `serrEn` is 1, `serrN` is 0 for one clock, two clocks after the address phase.
- R5: With `serrEn` at 0 an address parity mismatch leaves `serrN` at 1.
- R6: If `parIn` in the clock after a write data phase (`isRead` = 0, `irdyN` low) differs from `parOut`, `perrN` is 0 for one clock two clocks after that phase when `perrEn` is 1, and stays 1 when `perrEn` is 0.
- R7: In a transaction whose address-phase command is 4'b0001 (special cycle), data parity mismatches never drive `perrN` low but still set `dataErrFlag`.
- R8: Read data phases and wait-state clocks (ready strobe high) are never checked, whatever `parIn` carries in the following clock.
- R9: `addrErrFlag` and `dataErrFlag` are set in the same clock the matching error would appear on `serrN`/`perrN`, independent of the enables; they hold until `statClr` is sampled high, which clears them one clock later; a new error in that clock wins over the clear.
- R10: During and right after reset, `serrN` and `perrN` are 1, and `parOe`, `addrErrFlag` and `dataErrFlag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameN | input | 1 | Transaction framing, active low |
| irdyN | input | 1 | Initiator ready, active low |
| trdyN | input | 1 | Target ready, active low |
| isRead | input | 1 | 1 = current transaction reads (this side drives data) |
| adIn | input | 32 | Multiplexed address/data lines |
| cbeN | input | 4 | Command (address phase) or active-low byte enables |
| parIn | input | 1 | Parity bit received from the bus |
| serrEn | input | 1 | Enables driving of the system-error output |
| perrEn | input | 1 | Enables driving of the parity-error output |
| statClr | input | 1 | Clears both sticky flags |
| parOut | output | 1 | Generated parity, one clock after its phase |
| parOe | output | 1 | Parity output enable (after read data phases) |
| serrN | output | 1 | System error, 0 = pull low, 1 = released |
| perrN | output | 1 | Parity error, 0 = pull low, 1 = released |
| addrErrFlag | output | 1 | Sticky address parity error flag |
| dataErrFlag | output | 1 | Sticky data parity error flag |

## Verification
The two functions that meet in one clock are the setting of a sticky flag by a freshly detected mismatch and its clearing by `statClr`. The bench injects a wrong address parity and raises `statClr` in the very clock that carries the bad `parIn`, so the set and the clear are sampled at the same edge; the flag must read 1 afterwards, while a clear in a quiet clock must read 0 one clock later. A scoreboard predicts every output clock by clock from the requirement model and also keeps wait states and read phases with corrupted parity in the stream to show they stay unchecked.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

  // Strobes from the phase control to the parity datapath, valid in the
  // clock that carries the phase.
  typedef struct packed {
    logic capture;   // register parity of the current bus lines
    logic chkAddr;   // address phase, compare parIn next clock
    logic chkData;   // write data phase, compare parIn next clock
    logic drvRead;   // read data phase, drive parity next clock
    logic quiet;     // transaction is a special cycle
  } parStrobe_t;

endpackage

// File: rtl/pci_par_ctl.sv
module pci_par_ctl
  import pci_par_pkg::*;
#(
  parameter int CBE_W = 4,
  parameter logic [CBE_W-1:0] SPECIAL_CMD = 4'b0001
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameN,
  input  logic             irdyN,
  input  logic             trdyN,
  input  logic             isRead,
  input  logic [CBE_W-1:0] cbeN,
  output parStrobe_t       strobe
);

  logic busIdleQ;    // previous clock had frame and irdy both high
  logic inTxnQ;      // between address phase and bus idle
  logic specialQ;    // command of current transaction is special cycle
  logic addrPhase;
  logic wrQual;
  logic rdQual;

  assign addrPhase = busIdleQ && !frameN;
  assign wrQual    = inTxnQ && !isRead && !irdyN;
  assign rdQual    = inTxnQ &&  isRead && !trdyN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busIdleQ <= 1'b1;
      inTxnQ   <= 1'b0;
      specialQ <= 1'b0;
    end else begin
      busIdleQ <= frameN && irdyN;
      if (addrPhase) begin
        inTxnQ   <= 1'b1;
        specialQ <= (cbeN == SPECIAL_CMD);
      end else if (frameN && irdyN) begin
        inTxnQ <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.chkAddr = addrPhase;
    strobe.chkData = wrQual;
    strobe.drvRead = rdQual;
    strobe.capture = addrPhase || wrQual || rdQual;
    strobe.quiet   = specialQ;
  end

endmodule

// File: rtl/pci_par_dp.sv
module pci_par_dp
  import pci_par_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  parStrobe_t       strobe,
  input  logic [AD_W-1:0]  adIn,
  input  logic [CBE_W-1:0] cbeN,
  input  logic             parIn,
  input  logic             serrEn,
  input  logic             perrEn,
  input  logic             statClr,
  output logic             parOut,
  output logic             parOe,
  output logic             serrN,
  output logic             perrN,
  output logic             addrErrFlag,
  output logic             dataErrFlag
);

  localparam int LANE_W = AD_W / CBE_W;

  logic [CBE_W-1:0] laneX;
  logic             calcPar;

  // One parity leaf per byte lane, folding in that lane's enable line.
  for (genvar g = 0; g < CBE_W; g++) begin : gLane
    assign laneX[g] = (^adIn[g*LANE_W +: LANE_W]) ^ cbeN[g];
  end
  assign calcPar = ^laneX;

  logic parQ;
  logic oeQ;
  logic pendAddrQ;
  logic pendDataQ;
  logic quietQ;
  logic serrNQ;
  logic perrNQ;
  logic aFlagQ;
  logic dFlagQ;
  logic mismatch;
  logic addrErr;
  logic dataErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      parQ      <= 1'b0;
      oeQ       <= 1'b0;
      pendAddrQ <= 1'b0;
      pendDataQ <= 1'b0;
      quietQ    <= 1'b0;
    end else begin
      if (strobe.capture) parQ <= calcPar;
      oeQ       <= strobe.drvRead;
      pendAddrQ <= strobe.chkAddr;
      pendDataQ <= strobe.chkData;
      quietQ    <= strobe.quiet;
    end
  end

  assign mismatch = parIn ^ parQ;
  assign addrErr  = pendAddrQ && mismatch;
  assign dataErr  = pendDataQ && mismatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      serrNQ <= 1'b1;
      perrNQ <= 1'b1;
      aFlagQ <= 1'b0;
      dFlagQ <= 1'b0;
    end else begin
      serrNQ <= !(addrErr && serrEn);
      perrNQ <= !(dataErr && perrEn && !quietQ);
      aFlagQ <= addrErr || (aFlagQ && !statClr);
      dFlagQ <= dataErr || (dFlagQ && !statClr);
    end
  end

  assign parOut      = parQ;
  assign parOe       = oeQ;
  assign serrN       = serrNQ;
  assign perrN       = perrNQ;
  assign addrErrFlag = aFlagQ;
  assign dataErrFlag = dFlagQ;

endmodule

// File: rtl/pci_par_unit.sv
module pci_par_unit
  import pci_par_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameN,
  input  logic             irdyN,
  input  logic             trdyN,
  input  logic             isRead,
  input  logic [AD_W-1:0]  adIn,
  input  logic [CBE_W-1:0] cbeN,
  input  logic             parIn,
  input  logic             serrEn,
  input  logic             perrEn,
  input  logic             statClr,
  output logic             parOut,
  output logic             parOe,
  output logic             serrN,
  output logic             perrN,
  output logic             addrErrFlag,
  output logic             dataErrFlag
);

  parStrobe_t strobe;

  pci_par_ctl #(.CBE_W(CBE_W), .SPECIAL_CMD(CBE_W'(1))) uCtl (
    .clk    (clk),
    .rstN   (rstN),
    .frameN (frameN),
    .irdyN  (irdyN),
    .trdyN  (trdyN),
    .isRead (isRead),
    .cbeN   (cbeN),
    .strobe (strobe)
  );

  pci_par_dp #(.AD_W(AD_W), .CBE_W(CBE_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .adIn        (adIn),
    .cbeN        (cbeN),
    .parIn       (parIn),
    .serrEn      (serrEn),
    .perrEn      (perrEn),
    .statClr     (statClr),
    .parOut      (parOut),
    .parOe       (parOe),
    .serrN       (serrN),
    .perrN       (perrN),
    .addrErrFlag (addrErrFlag),
    .dataErrFlag (dataErrFlag)
  );

endmodule

// File: rtl/pci_par_chk.sv
module pci_par_chk #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             trdyN,
  input logic             isRead,
  input logic [AD_W-1:0]  adIn,
  input logic [CBE_W-1:0] cbeN,
  input logic             serrEn,
  input logic             perrEn,
  input logic             statClr,
  input logic             parOut,
  input logic             parOe,
  input logic             serrN,
  input logic             perrN,
  input logic             addrErrFlag,
  input logic             dataErrFlag
);

  AST_PAR_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    parOe |-> (((^$past(adIn)) ^ (^$past(cbeN)) ^ parOut) == 1'b0)); // R1

  AST_OE_AFTER_TRDY: assert property (@(posedge clk) disable iff (!rstN)
    parOe |-> $past(!trdyN && isRead)); // R3

  AST_SERR_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !serrN |-> $past(serrEn)); // R5

  AST_PERR_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !perrN |-> $past(perrEn)); // R6

  AST_SERR_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    !serrN |-> addrErrFlag); // R4

  AST_PERR_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    !perrN |-> dataErrFlag); // R9

  AST_AFLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(addrErrFlag) && !$past(statClr)) |-> addrErrFlag); // R9

  AST_DFLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(dataErrFlag) && !$past(statClr)) |-> dataErrFlag); // R9

endmodule

bind pci_par_unit pci_par_chk #(.AD_W(AD_W), .CBE_W(CBE_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .trdyN       (trdyN),
  .isRead      (isRead),
  .adIn        (adIn),
  .cbeN        (cbeN),
  .serrEn      (serrEn),
  .perrEn      (perrEn),
  .statClr     (statClr),
  .parOut      (parOut),
  .parOe       (parOe),
  .serrN       (serrN),
  .perrN       (perrN),
  .addrErrFlag (addrErrFlag),
  .dataErrFlag (dataErrFlag)
);

// File: tb/sim_pci_par_unit.sv
`timescale 1ns/1ps
module sim_pci_par_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameN = 1'b1, irdyN = 1'b1, trdyN = 1'b1, isRead = 1'b0;
  logic [31:0] adIn = '0;
  logic [3:0]  cbeN = '0;
  logic        parIn = 1'b0, serrEn = 1'b1, perrEn = 1'b1, statClr = 1'b0;
  logic        parOut, parOe, serrN, perrN, addrErrFlag, dataErrFlag;

  always #2.5 clk = ~clk;

  pci_par_unit u0 (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .trdyN(trdyN),
    .isRead(isRead), .adIn(adIn), .cbeN(cbeN), .parIn(parIn),
    .serrEn(serrEn), .perrEn(perrEn), .statClr(statClr),
    .parOut(parOut), .parOe(parOe), .serrN(serrN), .perrN(perrN),
    .addrErrFlag(addrErrFlag), .dataErrFlag(dataErrFlag)
  );

  typedef struct {
    int    due;
    int    kind;   // 0 parOut 1 parOe 2 serrN 3 perrN 4 addrFlag 5 dataFlag
    bit    val;
    string req;
  } expItem_t;

  expItem_t sb[$];
  int  cyc = 0;
  int  nTests = 0;
  int  nFail = 0;
  bit  done = 1'b0;

  // bench model of bus state, built from R2
  bit  mIdle = 1'b1, mInTxn = 1'b0, mSpecial = 1'b0;
  bit  nextPar = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit pick(int kind);
    case (kind)
      0: return parOut;
      1: return parOe;
      2: return serrN;
      3: return perrN;
      4: return addrErrFlag;
      default: return dataErrFlag;
    endcase
  endfunction

  task automatic check(string req, string what, bit act, bit exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s cycle %0d: actual %0b expected %0b", req, what, cyc, act, exp);
    end
  endtask

  task automatic push(int due, int kind, bit val, string req);
    expItem_t it;
    it.due = due; it.kind = kind; it.val = val; it.req = req;
    sb.push_back(it);
  endtask

  // monitor: pops due items at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
          if (sb[i].due == cyc) begin
            check(sb[i].req, $sformatf("kind%0d", sb[i].kind), pick(sb[i].kind), sb[i].val);
            sb.delete(i);
          end
        end
      end
    end
  end

  // driver: one bus clock; err corrupts the parity sent in the next clock
  task automatic slot(bit f, bit i, bit t, logic [31:0] ad, logic [3:0] cb,
                      bit rd, bit err, bit clr);
    bit  good, addr, wr, rq;
    int  s;
    s = cyc;
    frameN = f; irdyN = i; trdyN = t; adIn = ad; cbeN = cb; isRead = rd;
    statClr = clr; parIn = nextPar;
    good = ^{ad, cb};
    addr = mIdle && !f;
    wr   = mInTxn && !rd && !i;
    rq   = mInTxn && rd && !t;
    nextPar = good ^ err;
    if (addr || wr || rq) push(s + 1, 0, good, "R1");
    push(s + 1, 1, rq, "R3");
    push(s + 2, 2, !(addr && err && serrEn), addr ? "R4/R5" : "R2/R8");
    push(s + 2, 3, !(wr && err && perrEn && !(mSpecial && !addr)),
         wr ? (mSpecial ? "R7" : "R6") : "R8");
    if (addr && err) push(s + 2, 4, 1'b1, "R9");
    if (wr && err)   push(s + 2, 5, 1'b1, "R9");
    if (addr) begin mInTxn = 1'b1; mSpecial = (cb == 4'b0001); end
    else if (f && i) mInTxn = 1'b0;
    mIdle = f && i;
    @(posedge clk); #1;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) slot(1, 1, 1, 32'h0, 4'hF, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic clearFlags();
    push(cyc + 1, 4, 1'b0, "R9");
    push(cyc + 1, 5, 1'b0, "R9");
    slot(1, 1, 1, 32'h0, 4'hF, 1'b0, 1'b0, 1'b1);
    idle(1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R10", "serrN", serrN, 1'b1);
    check("R10", "perrN", perrN, 1'b1);
    check("R10", "parOe", parOe, 1'b0);
    check("R10", "addrErrFlag", addrErrFlag, 1'b0);
    check("R10", "dataErrFlag", dataErrFlag, 1'b0);
    @(posedge clk); #1;

    // clean write, wait state with corrupt parity (R2, R8)
    slot(0, 1, 1, 32'h1000_0040, 4'b0111, 0, 0, 0);
    slot(0, 0, 1, 32'hDEAD_BEEF, 4'b0000, 0, 0, 0);
    slot(0, 1, 1, 32'h5555_AAAA, 4'b0000, 0, 1, 0);
    slot(1, 0, 1, 32'h0123_4567, 4'b1100, 0, 0, 0);
    idle(2);

    // address parity error, reported (R4)
    slot(0, 1, 1, 32'h2000_0000, 4'b0111, 0, 1, 0);
    slot(1, 0, 1, 32'h0000_00FF, 4'b0000, 0, 0, 0);
    idle(2);
    // data parity error, reported (R6)
    slot(0, 1, 1, 32'h3000_0010, 4'b0111, 0, 0, 0);
    slot(1, 0, 1, 32'hF0F0_0F0F, 4'b0011, 0, 1, 0);
    idle(2);
    clearFlags();

    // enables off: outputs released, flags still set (R5, R6, R9)
    serrEn = 1'b0; perrEn = 1'b0;
    slot(0, 1, 1, 32'h4000_0000, 4'b0111, 0, 1, 0);
    slot(1, 0, 1, 32'h8765_4321, 4'b0000, 0, 1, 0);
    idle(2);
    serrEn = 1'b1; perrEn = 1'b1;
    clearFlags();

    // special cycle with a bad data phase (R7)
    slot(0, 1, 1, 32'h0000_0000, 4'b0001, 0, 0, 0);
    slot(0, 0, 1, 32'hABCD_0001, 4'b0000, 0, 1, 0);
    slot(1, 0, 1, 32'h1111_2222, 4'b0000, 0, 1, 0);
    idle(2);
    clearFlags();

    // read transaction: driven parity, target wait state, corrupt parIn (R3, R8)
    slot(0, 1, 1, 32'h5000_0080, 4'b0110, 1, 0, 0);
    slot(0, 0, 1, 32'h0000_0000, 4'b0000, 1, 1, 0);
    slot(0, 0, 0, 32'hCAFE_F00D, 4'b0000, 1, 1, 0);
    slot(1, 0, 0, 32'h7777_0001, 4'b0000, 1, 1, 0);
    idle(2);
    check("R9", "dataErrFlag after read", dataErrFlag, 1'b0);

    // set and clear in the same clock: set wins (R9)
    slot(0, 1, 1, 32'h6000_0004, 4'b0111, 0, 1, 0);
    slot(1, 0, 1, 32'h0000_0001, 4'b0000, 0, 0, 1);
    idle(3);

    repeat (4) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done == 1'b1 && sb.size() == 0);
      begin
        repeat (20000) @(posedge clk);
        nFail++;
        nTests++;
        $display("FAIL watchdog expired, %0d items pending", sb.size());
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule